// File: doc/BRIEF.md
# Majority-Vote Serial Byte Receiver

This block takes a single asynchronous serial input line and turns each frame into a parallel byte. A frame is one start bit (low), eight data bits sent least-significant first, and one stop bit (high). The line idles high. All bit timing comes from one oversample enable. It pulses once every `CLK_DIV` system clocks, which gives sixteen enables per bit period. Changing that one divisor rescales every internal delay.

The input first passes through a two-stage synchroniser. A low level on an idle line starts a frame. The block counts oversample ticks from that edge. Within every bit, including the start and stop bits, it samples the line at ticks 7, 8 and 9 of 16 and keeps the level seen at least twice. A start bit that votes high at its centre is treated as noise, and the block re-arms without output. When the stop bit is decided, the byte is presented with a one-cycle valid strobe. If the stop bit voted low, a framing-error flag is raised in that same cycle. After a framing error the block waits for the line to go high before it looks for a new start.

Top module: `uart_vote_rx`

## Requirements
- R1: The oversample enable pulses exactly once every `CLK_DIV` system clocks, and one bit period is 16 enables (64 clocks at `CLK_DIV`=4). A frame sent at that bit period is decoded.
- R2: The serial input is re-timed by two flip-flops. A line held high (idle) produces no valid strobe.
- R3: A low level on the idle line starts a frame. If the start bit votes high at its centre, the block returns to idle. It produces no valid strobe and leaves `data_o` unchanged.
- R4: Each bit is decided by a majority of three samples taken at oversample ticks 7, 8 and 9 of the bit. A disturbance that corrupts only one of the three samples does not change the decoded bit.
- R5: Eight data bits are received least-significant bit first. The first bit after the start bit lands in `data_o[0]`.
- R6: `valid_o` is high for exactly one system clock per completed frame. `data_o` changes only in that cycle and holds until the next completed frame.
- R7: If the stop bit votes low, `frame_err_o` is high in the same cycle as `valid_o`, and the received byte is still presented. No new frame is accepted until the line has been seen high again. If the stop bit votes high, `frame_err_o` stays low.
- R8: After reset, `valid_o`, `frame_err_o` and `data_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial input, idle high |
| data_o | output | 8 | Last received byte, held between frames |
| valid_o | output | 1 | One-cycle strobe marking a completed frame |
| frame_err_o | output | 1 | Stop bit voted low; high only together with `valid_o` |

## Verification
Some properties are checked by assertions on every cycle:
- the enable pulses exactly every `CLK_DIV` clocks;
- the valid strobe never lasts two cycles;
- the byte output changes only under the strobe;
- the framing-error flag never appears without the strobe.

Other behaviour only the directed scenarios can show:
- bit order;
- the vote rejecting a single corrupted sample (a glitch swept across the three sample points);
- start glitches being discarded;
- the wait for a high line after a framing error.

// File: rtl/uvr_pkg.sv
package uvr_pkg;
   typedef enum logic [2:0] {
      RX_IDLE  = 3'd0,
      RX_START = 3'd1,
      RX_DATA  = 3'd2,
      RX_STOP  = 3'd3,
      RX_HOLD  = 3'd4
   } rx_state_t;
endpackage

// File: rtl/uvr_tick_gen.sv
module uvr_tick_gen #(
   parameter int CLK_DIV = 54
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("uvr_tick_gen: CLK_DIV must be at least 1");
      end else if (CLK_DIV == 1) begin : g_every_clock
         assign tick_o = 1'b1;
      end else begin : g_counter
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (cnt_q == CNT_LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign tick_o = (cnt_q == CNT_LAST);
      end
   endgenerate
endmodule

// File: rtl/uvr_sync.sv
module uvr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("uvr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe_q <= '1;
      end else begin
         pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/uvr_vote.sv
module uvr_vote (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_en_i,
   input  logic din_i,
   output logic vote_o
);
   logic [1:0] hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= 2'b11;
      end else if (smp_en_i) begin
         hist_q <= {hist_q[0], din_i};
      end
   end

   // majority of the two stored samples and the one being taken now
   assign vote_o = (hist_q[1] & hist_q[0]) | (hist_q[1] & din_i) | (hist_q[0] & din_i);
endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx
   import uvr_pkg::*;
#(
   parameter int CLK_DIV = 54,
   parameter int OVS     = 16,
   parameter int DATA_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_i,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o,
   output logic              frame_err_o
);
   localparam int PH_W  = $clog2(OVS);
   localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [PH_W-1:0]  PH_FIRST = PH_W'(OVS / 2 - 1);
   localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(OVS / 2 + 1);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

   generate
      if (OVS < 8 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("uart_vote_rx: OVS must be a power of two, at least 8");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("uart_vote_rx: DATA_W must be at least 1");
      end
   endgenerate

   logic tick;
   logic rx_s;
   logic vote;
   logic smp_en;

   rx_state_t         st_q;
   logic [PH_W-1:0]   ph_q;
   logic [BIT_W-1:0]  bit_q;
   logic [DATA_W-1:0] shr_q;

   uvr_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   uvr_sync #(.STAGES(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rx_i),
      .q_o   (rx_s)
   );

   logic in_frame;
   assign in_frame = (st_q == RX_START) || (st_q == RX_DATA) || (st_q == RX_STOP);
   assign smp_en   = in_frame && tick && (ph_q >= PH_FIRST) && (ph_q <= PH_LAST);

   uvr_vote u_vote (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_en_i (smp_en),
      .din_i    (rx_s),
      .vote_o   (vote)
   );

   logic decide;
   assign decide = in_frame && tick && (ph_q == PH_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= RX_IDLE;
         ph_q        <= '0;
         bit_q       <= '0;
         shr_q       <= '0;
         data_o      <= '0;
         valid_o     <= 1'b0;
         frame_err_o <= 1'b0;
      end else begin
         valid_o     <= 1'b0;
         frame_err_o <= 1'b0;
         if (in_frame && tick) begin
            ph_q <= ph_q + 1'b1;
         end
         unique case (st_q)
            RX_IDLE: begin
               if (!rx_s) begin
                  st_q <= RX_START;
                  ph_q <= '0;
               end
            end
            RX_START: begin
               if (decide) begin
                  if (vote) begin
                     st_q <= RX_IDLE;
                  end else begin
                     st_q  <= RX_DATA;
                     bit_q <= '0;
                  end
               end
            end
            RX_DATA: begin
               if (decide) begin
                  shr_q <= {vote, shr_q[DATA_W-1:1]};
                  if (bit_q == BIT_LAST) begin
                     st_q <= RX_STOP;
                  end else begin
                     bit_q <= bit_q + 1'b1;
                  end
               end
            end
            RX_STOP: begin
               if (decide) begin
                  valid_o     <= 1'b1;
                  frame_err_o <= !vote;
                  data_o      <= shr_q;
                  st_q        <= vote ? RX_IDLE : RX_HOLD;
               end
            end
            RX_HOLD: begin
               if (rx_s) begin
                  st_q <= RX_IDLE;
               end
            end
            default: st_q <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uvr_checker.sv
module uvr_checker #(
   parameter int CLK_DIV = 54,
   parameter int DATA_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic [DATA_W-1:0] data_o,
   input logic              valid_o,
   input logic              frame_err_o
);
   int unsigned since_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_tick <= 0;
      end else if (tick) begin
         since_tick <= 0;
      end else begin
         since_tick <= since_tick + 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         AST_TICK_PERIOD: assert (tick == (since_tick == CLK_DIV - 1)); // R1
      end
   end

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o); // R6

   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> $stable(data_o)); // R6

   AST_FERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o |-> valid_o); // R7
endmodule

bind uart_vote_rx uvr_checker #(.CLK_DIV(CLK_DIV), .DATA_W(DATA_W)) u_uvr_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick        (tick),
   .data_o      (data_o),
   .valid_o     (valid_o),
   .frame_err_o (frame_err_o)
);

// File: tb/tb_uart_vote_rx.sv
`timescale 1ns/1ps
module tb_uart_vote_rx;
   localparam int DIV = 4;
   localparam int BIT = DIV * 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx = 1'b1;
   logic [7:0] data;
   logic       valid;
   logic       ferr;

   int checks = 0;
   int errors = 0;
   int vcnt = 0;
   logic [7:0] last_data = 8'h00;
   logic       last_ferr = 1'b0;
   logic       prev_valid = 1'b0;
   int         long_pulses = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   uart_vote_rx #(.CLK_DIV(DIV), .OVS(16), .DATA_W(8)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_i        (rx),
      .data_o      (data),
      .valid_o     (valid),
      .frame_err_o (ferr)
   );

   always @(negedge clk) begin
      if (valid) begin
         vcnt      <= vcnt + 1;
         last_data <= data;
         last_ferr <= ferr;
         if (prev_valid) long_pulses <= long_pulses + 1;
      end
      prev_valid <= valid;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx = 1'b1;
      end
   endtask

   // gbit: bit slot (0 = start, 9 = stop) to disturb; goff: clock offset of a 4-clock inversion
   task automatic send_frame(input logic [7:0] b, input logic stop_lvl, input int gbit, input int goff);
      for (int i = 0; i < 10; i++) begin
         logic lvl;
         lvl = (i == 0) ? 1'b0 : (i == 9) ? stop_lvl : b[i-1];
         for (int c = 0; c < BIT; c++) begin
            @(negedge clk);
            rx = lvl ^ ((i == gbit) && (c >= goff) && (c < goff + 4));
         end
      end
   endtask

   task automatic expect_frame(input logic [7:0] b, input string tag);
      int v0;
      v0 = vcnt;
      send_frame(b, 1'b1, -1, 0);
      idle(40);
      check(vcnt == v0 + 1, tag, vcnt - v0, 1);
      check(last_data == b, tag, last_data, b);
      check(last_ferr == 1'b0, tag, last_ferr, 0);
   endtask

   task automatic t_reset;
      check(valid == 1'b0, "R8 valid", valid, 0);
      check(ferr == 1'b0, "R8 ferr", ferr, 0);
      check(data == 8'h00, "R8 data", data, 0);
      idle(300);
      check(vcnt == 0, "R2 idle line gives no strobe", vcnt, 0);
   endtask

   task automatic t_basic;
      expect_frame(8'hA5, "R1 frame A5");
      expect_frame(8'h01, "R5 lsb first 01");
      expect_frame(8'h80, "R5 msb last 80");
      expect_frame(8'h3C, "R5 pattern 3C");
   endtask

   task automatic t_start_glitch;
      int v0;
      v0 = vcnt;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         rx = 1'b0;
      end
      idle(300);
      check(vcnt == v0, "R3 short low pulse ignored", vcnt - v0, 0);
      check(data == 8'h3C, "R3 data unchanged after glitch", data, 8'h3C);
      expect_frame(8'hC3, "R3 frame after glitch");
   endtask

   task automatic t_vote;
      int v0;
      for (int k = 0; k < 4; k++) begin
         v0 = vcnt;
         send_frame(8'h5A, 1'b1, 4, 30 + 4 * k);
         idle(40);
         check(vcnt == v0 + 1 && last_data == 8'h5A, "R4 single-sample glitch in data bit",
               last_data, 8'h5A);
      end
      for (int k = 0; k < 4; k++) begin
         v0 = vcnt;
         send_frame(8'h96, 1'b1, 0, 30 + 4 * k);
         idle(40);
         check(vcnt == v0 + 1 && last_data == 8'h96, "R4 single-sample glitch in start bit",
               last_data, 8'h96);
      end
      check(data == 8'h96, "R6 data held after strobe", data, 8'h96);
   endtask

   task automatic t_frame_err;
      int v0;
      v0 = vcnt;
      send_frame(8'h66, 1'b0, -1, 0);
      for (int i = 0; i < 3 * BIT * 10; i++) begin
         @(negedge clk);
         rx = 1'b0;
      end
      check(vcnt == v0 + 1, "R7 one strobe while line stays low", vcnt - v0, 1);
      check(last_ferr == 1'b1, "R7 framing error flag", last_ferr, 1);
      check(last_data == 8'h66, "R7 byte still presented", last_data, 8'h66);
      idle(60);
      expect_frame(8'h99, "R7 rearm after line high");
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_start_glitch();
      t_vote();
      t_frame_err();
      check(long_pulses == 0, "R6 strobe one cycle", long_pulses, 0);
      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule